// File: doc/BRIEF.md
# Banked Index/Data Configuration Space

This block is a small configuration space that a host reaches through two byte-wide ports. The host first writes a register number to the index port. It then reads or writes the selected register through the data port. A logical-device-number register chooses one of several register banks. Each bank holds an activate bit, two 16-bit I/O base addresses, an interrupt number/wakeup select byte and an interrupt type byte. Two unbanked read-only registers report an identification byte and a revision number.

For one chosen logical device (the mailbox device, number 0x12 by default), the block drives its activate flag and its two base addresses to the neighbouring decode logic. Each base address is written one byte at a time. The high byte is held in a staging register. The address seen by the decode logic changes only when the low byte is written, so that logic never sees a half-updated address. The data port read value is combinational from the current index, the current device number and the register contents.

Top module: `icfg_space`

## Requirements
- R1: After synchronous reset the index, the logical device number and every bank register are zero, dev_active is 0 and both base outputs are 0x0000.
- R2: An index port write takes effect at the next clock edge, and from then on dat_rdata shows the register that index selects.
- R3: Index 0x20 always reads 0xEF, and data writes to it change nothing.
- R4: Index 0x27 reads {3'b000, REVISION} (0x05 by default), and data writes to it change nothing.
- R5: Index 0x07 is the read/write logical device number. Banks exist for device numbers BANK_FIRST to BANK_FIRST+NUM_BANKS-1 (0x10 to 0x13 by default), and a data write reaches only the bank of the current device number.
- R6: While the device number has no bank, the banked indices (0x30, 0x60 to 0x63, 0x70, 0x71) read 0xFF and data writes to them change nothing.
- R7: Any index that is not listed in R3 to R6 or R8 to R10 reads 0xFF, and data writes to it change nothing.
- R8: Index 0x30 stores bit 0 of the written byte and reads back 0x00 or 0x01. dev_active follows that bit of the TARGET_LDN bank (0x12 by default) from the edge of the write.
- R9: Indices 0x60/0x61 are the high/low bytes of base 0, and 0x62/0x63 are those of base 1. A high-byte write only stages the byte. A low-byte write loads {staged high, written low} into the base. Reads return the staged high byte and the loaded low byte. dev_base0 and dev_base1 show the TARGET_LDN bank's loaded bases.
- R10: Index 0x70 (interrupt number/wakeup) and index 0x71 (interrupt type) each store and return a full byte per bank.
- R11: When an index write and a data write fall in the same cycle, the data write goes to the index held before that cycle, and the new index applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idx_we | input | 1 | Index port write strobe |
| idx_wdata | input | 8 | Register number to select |
| dat_we | input | 1 | Data port write strobe |
| dat_wdata | input | 8 | Byte written to the selected register |
| dat_rdata | output | 8 | Contents of the selected register |
| dev_active | output | 1 | Activate bit of the target device bank |
| dev_base0 | output | 16 | Loaded I/O base 0 of the target device bank |
| dev_base1 | output | 16 | Loaded I/O base 1 of the target device bank |

## Verification
The index port and the data port can both be written in the same cycle. The data write must land on the old index while the index register loads the new one. The bench provokes this directly and also in random traffic. A behavioural model applies the data write before it updates its own index, and the result is judged by reading both registers back. The other collision is a device-number change combined with banked traffic. Here the model tracks which bank each write reaches, and it compares dat_rdata, dev_active and both base outputs after every clock edge.

// File: rtl/icfg_pkg.sv
`timescale 1ns/1ps
package icfg_pkg;

    localparam logic [7:0] IDX_LDN  = 8'h07;
    localparam logic [7:0] IDX_ID   = 8'h20;
    localparam logic [7:0] IDX_REV  = 8'h27;
    localparam logic [7:0] IDX_ACT  = 8'h30;
    localparam logic [7:0] IDX_B0H  = 8'h60;
    localparam logic [7:0] IDX_B0L  = 8'h61;
    localparam logic [7:0] IDX_B1H  = 8'h62;
    localparam logic [7:0] IDX_B1L  = 8'h63;
    localparam logic [7:0] IDX_IRQ  = 8'h70;
    localparam logic [7:0] IDX_ITYP = 8'h71;

    localparam logic [7:0] ID_VALUE = 8'hEF;
    localparam logic [7:0] RD_EMPTY = 8'hFF;

    typedef struct packed {
        logic        act;
        logic [7:0]  b0_hi;
        logic [15:0] b0;
        logic [7:0]  b1_hi;
        logic [15:0] b1;
        logic [7:0]  irq_sel;
        logic [7:0]  irq_kind;
    } bank_t;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_LDN,
        SRC_ID,
        SRC_REV,
        SRC_BANK
    } rd_src_e;

    function automatic rd_src_e classify(input logic [7:0] i);
        rd_src_e s;
        case (i)
            IDX_LDN:  s = SRC_LDN;
            IDX_ID:   s = SRC_ID;
            IDX_REV:  s = SRC_REV;
            IDX_ACT, IDX_B0H, IDX_B0L, IDX_B1H,
            IDX_B1L, IDX_IRQ, IDX_ITYP: s = SRC_BANK;
            default:  s = SRC_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [7:0] bank_field(input bank_t b, input logic [7:0] i);
        logic [7:0] v;
        case (i)
            IDX_ACT:  v = {7'b0, b.act};
            IDX_B0H:  v = b.b0_hi;
            IDX_B0L:  v = b.b0[7:0];
            IDX_B1H:  v = b.b1_hi;
            IDX_B1L:  v = b.b1[7:0];
            IDX_IRQ:  v = b.irq_sel;
            IDX_ITYP: v = b.irq_kind;
            default:  v = RD_EMPTY;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/icfg_ctrl.sv
`timescale 1ns/1ps
module icfg_ctrl
    import icfg_pkg::*;
#(
    parameter logic [7:0] BANK_FIRST = 8'h10,
    parameter int          NUM_BANKS  = 4,
    parameter int          SEL_W      = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 idx_we,
    input  logic [7:0]           idx_wdata,
    input  logic                 dat_we,
    input  logic [7:0]           dat_wdata,
    output logic [7:0]           idx_q,
    output logic [7:0]           ldn_q,
    output logic                 bank_hit,
    output logic [SEL_W-1:0]     bank_sel,
    output logic [NUM_BANKS-1:0] bank_we
);

    logic banked_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            ldn_q <= '0;
        end else begin
            if (idx_we)
                idx_q <= idx_wdata;
            if (dat_we && idx_q == IDX_LDN)
                ldn_q <= dat_wdata;
        end
    end

    always_comb begin
        bank_hit   = (int'(ldn_q) >= int'(BANK_FIRST)) &&
                     (int'(ldn_q) <  int'(BANK_FIRST) + NUM_BANKS);
        bank_sel   = SEL_W'(ldn_q - BANK_FIRST);
        banked_idx = (classify(idx_q) == SRC_BANK);
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_we
        assign bank_we[b] = dat_we && banked_idx && bank_hit && (bank_sel == SEL_W'(b));
    end

    AST_IDX_LOADS: assert property (@(posedge clk) disable iff (rst)
        idx_we |=> idx_q == $past(idx_wdata)); // R2

    AST_LDN_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        !(dat_we && idx_q == IDX_LDN) |=> $stable(ldn_q)); // R5

    AST_ONE_BANK_WRITE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bank_we)); // R5

endmodule

// File: rtl/icfg_bank.sv
`timescale 1ns/1ps
module icfg_bank
    import icfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [7:0] widx,
    input  logic [7:0] wdata,
    output bank_t      st
);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (we) begin
            case (widx)
                IDX_ACT:  st.act      <= wdata[0];
                IDX_B0H:  st.b0_hi    <= wdata;
                IDX_B0L:  st.b0       <= {st.b0_hi, wdata};
                IDX_B1H:  st.b1_hi    <= wdata;
                IDX_B1L:  st.b1       <= {st.b1_hi, wdata};
                IDX_IRQ:  st.irq_sel  <= wdata;
                IDX_ITYP: st.irq_kind <= wdata;
                default:  ;
            endcase
        end
    end

    AST_BASE0_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(we && widx == IDX_B0L) |=> $stable(st.b0)); // R9

    AST_BASE1_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(we && widx == IDX_B1L) |=> $stable(st.b1)); // R9

    AST_BASE0_LOW_LANDS: assert property (@(posedge clk) disable iff (rst)
        (we && widx == IDX_B0L) |=> st.b0[7:0] == $past(wdata)); // R9

    AST_ACT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(we && widx == IDX_ACT) |=> $stable(st.act)); // R8

endmodule

// File: rtl/icfg_rdmux.sv
`timescale 1ns/1ps
module icfg_rdmux
    import icfg_pkg::*;
#(
    parameter logic [4:0] REVISION = 5'h05
) (
    input  logic [7:0] idx,
    input  logic [7:0] ldn,
    input  logic       bank_hit,
    input  bank_t      cur,
    output logic [7:0] rdata
);

    always_comb begin
        case (classify(idx))
            SRC_LDN:  rdata = ldn;
            SRC_ID:   rdata = ID_VALUE;
            SRC_REV:  rdata = {3'b000, REVISION};
            SRC_BANK: rdata = bank_hit ? bank_field(cur, idx) : RD_EMPTY;
            default:  rdata = RD_EMPTY;
        endcase
    end

endmodule

// File: rtl/icfg_space.sv
`timescale 1ns/1ps
module icfg_space
    import icfg_pkg::*;
#(
    parameter logic [7:0] BANK_FIRST = 8'h10,
    parameter int          NUM_BANKS  = 4,
    parameter logic [7:0] TARGET_LDN = 8'h12,
    parameter logic [4:0] REVISION   = 5'h05
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        idx_we,
    input  logic [7:0]  idx_wdata,
    input  logic        dat_we,
    input  logic [7:0]  dat_wdata,
    output logic [7:0]  dat_rdata,
    output logic        dev_active,
    output logic [15:0] dev_base0,
    output logic [15:0] dev_base1
);

    localparam int SEL_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
    localparam int TGT_SEL = int'(TARGET_LDN) - int'(BANK_FIRST);

    logic [7:0]           idx_q;
    logic [7:0]           ldn_q;
    logic                 bank_hit;
    logic [SEL_W-1:0]     bank_sel;
    logic [NUM_BANKS-1:0] bank_we;
    bank_t                banks [NUM_BANKS];
    bank_t                cur;

    icfg_ctrl #(
        .BANK_FIRST (BANK_FIRST),
        .NUM_BANKS  (NUM_BANKS),
        .SEL_W      (SEL_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .idx_we    (idx_we),
        .idx_wdata (idx_wdata),
        .dat_we    (dat_we),
        .dat_wdata (dat_wdata),
        .idx_q     (idx_q),
        .ldn_q     (ldn_q),
        .bank_hit  (bank_hit),
        .bank_sel  (bank_sel),
        .bank_we   (bank_we)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        icfg_bank u_bank (
            .clk   (clk),
            .rst   (rst),
            .we    (bank_we[b]),
            .widx  (idx_q),
            .wdata (dat_wdata),
            .st    (banks[b])
        );
    end

    always_comb begin
        cur = '0;
        for (int b = 0; b < NUM_BANKS; b++)
            if (bank_sel == SEL_W'(b))
                cur = banks[b];
    end

    icfg_rdmux #(
        .REVISION (REVISION)
    ) u_rdmux (
        .idx      (idx_q),
        .ldn      (ldn_q),
        .bank_hit (bank_hit),
        .cur      (cur),
        .rdata    (dat_rdata)
    );

    assign dev_active = banks[TGT_SEL].act;
    assign dev_base0  = banks[TGT_SEL].b0;
    assign dev_base1  = banks[TGT_SEL].b1;

    AST_ID_READ: assert property (@(posedge clk) disable iff (rst)
        (idx_q == IDX_ID) |-> dat_rdata == ID_VALUE); // R3

    AST_NO_BANK_READS_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (classify(idx_q) == SRC_BANK && !bank_hit) |-> dat_rdata == RD_EMPTY); // R6

    AST_ACTIVE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        !dat_we |=> $stable(dev_active)); // R8

    AST_BASE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        !dat_we |=> $stable(dev_base0) && $stable(dev_base1)); // R9

endmodule

// File: tb/test_icfg_space.sv
`timescale 1ns/1ps
module test_icfg_space;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        idx_we = 1'b0;
    logic [7:0]  idx_wdata = '0;
    logic        dat_we = 1'b0;
    logic [7:0]  dat_wdata = '0;
    logic [7:0]  dat_rdata;
    logic        dev_active;
    logic [15:0] dev_base0;
    logic [15:0] dev_base1;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    icfg_space i_icfg_space (
        .clk        (clk),
        .rst        (rst),
        .idx_we     (idx_we),
        .idx_wdata  (idx_wdata),
        .dat_we     (dat_we),
        .dat_wdata  (dat_wdata),
        .dat_rdata  (dat_rdata),
        .dev_active (dev_active),
        .dev_base0  (dev_base0),
        .dev_base1  (dev_base1)
    );

    // behavioural reference model
    int       m_idx;
    int       m_ldn;
    int       m_act  [256];
    int       m_h0   [256];
    int       m_b0   [256];
    int       m_h1   [256];
    int       m_b1   [256];
    int       m_irq  [256];
    int       m_typ  [256];

    function automatic bit has_bank(int l);
        return (l >= 'h10) && (l <= 'h13);
    endfunction

    function automatic bit banked(int i);
        return i == 'h30 || i == 'h60 || i == 'h61 || i == 'h62 ||
               i == 'h63 || i == 'h70 || i == 'h71;
    endfunction

    function automatic int expect_read();
        int l = m_ldn;
        if (m_idx == 'h07) return m_ldn;
        if (m_idx == 'h20) return 'hEF;
        if (m_idx == 'h27) return 'h05;
        if (banked(m_idx)) begin
            if (!has_bank(l)) return 'hFF;
            case (m_idx)
                'h30: return m_act[l];
                'h60: return m_h0[l];
                'h61: return m_b0[l] % 256;
                'h62: return m_h1[l];
                'h63: return m_b1[l] % 256;
                'h70: return m_irq[l];
                default: return m_typ[l];
            endcase
        end
        return 'hFF;
    endfunction

    function automatic string tag_for(int i);
        if (i == 'h07) return "R5";
        if (i == 'h20) return "R3";
        if (i == 'h27) return "R4";
        if (banked(i) && !has_bank(m_ldn)) return "R6";
        if (i == 'h30) return "R8";
        if (i >= 'h60 && i <= 'h63) return "R9";
        if (i == 'h70 || i == 'h71) return "R10";
        return "R7";
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_idx = 0;
        m_ldn = 0;
        for (int k = 0; k < 256; k++) begin
            m_act[k] = 0; m_h0[k] = 0; m_b0[k] = 0; m_h1[k] = 0;
            m_b1[k] = 0; m_irq[k] = 0; m_typ[k] = 0;
        end
    endtask

    task automatic model_write(int i, int d);
        int l = m_ldn;
        if (i == 'h07) begin
            m_ldn = d;
        end else if (banked(i) && has_bank(l)) begin
            case (i)
                'h30: m_act[l] = d % 2;
                'h60: m_h0[l]  = d;
                'h61: m_b0[l]  = m_h0[l] * 256 + d;
                'h62: m_h1[l]  = d;
                'h63: m_b1[l]  = m_h1[l] * 256 + d;
                'h70: m_irq[l] = d;
                default: m_typ[l] = d;
            endcase
        end
    endtask

    // step the model on every edge, compare shortly after
    always begin
        @(posedge clk);
        if (rst) begin
            model_reset();
        end else begin
            if (dat_we) model_write(m_idx, int'(dat_wdata));   // R11: old index first
            if (idx_we) m_idx = int'(idx_wdata);
        end
        #1;
        if (!done) begin
            chk(rst ? "R1" : tag_for(m_idx), int'(dat_rdata), expect_read());
            chk(rst ? "R1" : "R8", int'(dev_active), m_act['h12]);
            chk(rst ? "R1" : "R9", int'(dev_base0), m_b0['h12]);
            chk(rst ? "R1" : "R9", int'(dev_base1), m_b1['h12]);
        end
    end

    task automatic put(bit iw, logic [7:0] iv, bit dw, logic [7:0] dv);
        @(negedge clk);
        idx_we = iw; idx_wdata = iv; dat_we = dw; dat_wdata = dv;
        @(posedge clk);
        #2;
        idx_we = 1'b0; dat_we = 1'b0;
    endtask

    task automatic wr(logic [7:0] i, logic [7:0] d);
        put(1'b1, i, 1'b0, 8'h00);
        put(1'b0, 8'h00, 1'b1, d);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #2;
        // R1: reset state seen at the ports
        chk("R1", int'(dat_rdata), 'hFF);
        chk("R1", int'(dev_active), 0);
        chk("R1", int'(dev_base0), 0);

        // R2: index selects what the data port shows
        put(1'b1, 8'h07, 1'b0, 8'h00);
        chk("R2", int'(dat_rdata), 0);
        put(1'b1, 8'h20, 1'b0, 8'h00);
        chk("R2", int'(dat_rdata), 'hEF);

        // R3 / R4 / R7: read-only and unimplemented writes ignored
        put(1'b0, 8'h00, 1'b1, 8'h55);
        chk("R3", int'(dat_rdata), 'hEF);
        wr(8'h27, 8'hAA);
        chk("R4", int'(dat_rdata), 'h05);
        wr(8'h45, 8'h12);
        chk("R7", int'(dat_rdata), 'hFF);

        // R6: no bank for device 0x05
        wr(8'h07, 8'h05);
        wr(8'h30, 8'h01);
        chk("R6", int'(dat_rdata), 'hFF);
        chk("R6", int'(dev_active), 0);

        // R9: high byte stages only, low byte loads
        wr(8'h07, 8'h12);
        wr(8'h60, 8'h1A);
        chk("R9", int'(dev_base0), 0);
        chk("R9", int'(dat_rdata), 'h1A);
        wr(8'h61, 8'h2B);
        chk("R9", int'(dev_base0), 'h1A2B);
        wr(8'h62, 8'hC0);
        wr(8'h63, 8'h04);
        chk("R9", int'(dev_base1), 'hC004);

        // R8: activate bit 0 only
        wr(8'h30, 8'hFE);
        chk("R8", int'(dev_active), 0);
        wr(8'h30, 8'h01);
        chk("R8", int'(dev_active), 1);
        chk("R8", int'(dat_rdata), 1);

        // R5: another bank does not disturb the target outputs
        wr(8'h07, 8'h10);
        wr(8'h30, 8'h00);
        wr(8'h61, 8'h99);
        chk("R5", int'(dev_active), 1);
        chk("R5", int'(dev_base0), 'h1A2B);

        // R10 and R11: same-cycle index and data write
        wr(8'h07, 8'h12);
        wr(8'h71, 8'h44);
        put(1'b1, 8'h70, 1'b0, 8'h00);
        put(1'b1, 8'h71, 1'b1, 8'h3C);
        chk("R11", int'(dat_rdata), 'h44);
        put(1'b1, 8'h70, 1'b0, 8'h00);
        chk("R11", int'(dat_rdata), 'h3C);
        chk("R10", int'(dat_rdata), 'h3C);

        // random traffic against the model
        for (int n = 0; n < 600; n++) begin
            logic [7:0] pick [12] = '{8'h07, 8'h20, 8'h27, 8'h30, 8'h60, 8'h61,
                                      8'h62, 8'h63, 8'h70, 8'h71, 8'h45, 8'hFF};
            logic [7:0] iv = pick[$urandom_range(0, 11)];
            logic [7:0] dv = 8'($urandom_range(0, 255));
            bit iw = ($urandom_range(0, 2) != 0);
            bit dw = ($urandom_range(0, 1) != 0);
            if (m_idx == 'h07) dv = 8'($urandom_range('h0E, 'h15));
            put(iw, iv, dw, dv);
        end

        done = 1;
        summary();
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule